// File: doc/BRIEF.md
# Code Epoch Counter with Preload

This block keeps track of where one correlation channel stands inside a one-second navigation frame. Two counters are chained. The inner counter advances once per code period (1 ms) and marks the position inside a 20 ms data bit. The outer counter advances each time the inner one wraps, and marks the data bit inside the second. The channel's code generator supplies the code-period strobe. A free-running timing strobe (the TIC) snapshots the counter pair so that software can read a coherent value.

Software can align the counters with the bit boundaries of the received data by writing a preload pair. A mode input, sampled with the write strobe, picks when the value lands. In immediate mode it enters the counters on the next clock edge. In deferred mode it is held and enters the counters at the next TIC. All ports are plain register-style signals. No data stream crosses the block's edge, so there is no valid/ready handshake and no back-pressure.

Top module: `code_epoch_tracker`

## Requirements
- R1: A synchronous reset sets both counters and both snapshot fields to 0 and discards any pending deferred preload.
- R2: Each cycle with `period_stb` high and no load advances the inner count by one, from 0 up to 19 and then back to 0.
- R3: When the inner count wraps from 19 to 0, the outer count advances in the same edge, counting 0 through 49 and then back to 0. A strobe at 19/49 therefore gives 0/0.
- R4: A write with `ld_deferred` = 0 (immediate) places the preload pair in the counters at that edge and overrides a same-cycle strobe. It also discards any pending deferred value.
- R5: A write with `ld_deferred` = 1 holds the pair and loads it into the counters at the next TIC, overriding that cycle's strobe. A later deferred write before the TIC replaces the held pair.
- R6: A held deferred pair is applied only once. Later TICs with no new write leave the counters counting normally.
- R7: On every cycle with `tic_stb` high, the snapshot outputs take the counter pair as it stood before that cycle's increment or load. Between TICs the snapshot does not change.
- R8: `live_ms` and `live_bit` always show the current counter pair, one edge after the event that changed it.
- R9: A preload field outside its range (inner above 19, outer above 49) is loaded as 0. Fields that are in range are kept.
- R10: A deferred write in the same cycle as a TIC does not load at that TIC. That TIC applies the previously held pair, if any, and the new pair waits for the following TIC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| period_stb | input | 1 | One-cycle pulse per completed code period |
| tic_stb | input | 1 | One-cycle timing strobe: snapshot and deferred-load point |
| ld_wr | input | 1 | Preload write strobe |
| ld_deferred | input | 1 | 0 = load at once, 1 = load at next TIC; sampled with `ld_wr` |
| ld_ms | input | 5 | Preload value for the inner (1 ms) count |
| ld_bit | input | 6 | Preload value for the outer (20 ms) count |
| live_ms | output | 5 | Current inner count |
| live_bit | output | 6 | Current outer count |
| snap_ms | output | 5 | Inner count captured at the last TIC |
| snap_bit | output | 6 | Outer count captured at the last TIC |

## Verification
The assertions assume that every strobe is a synchronous level that is meaningful in the cycle it is high, and that `ld_ms` and `ld_bit` are stable whenever `ld_wr` is high. They place no limit on the preload range. The stimulus drives all inputs between clock edges, so each input holds a single value across an edge. The random preload fields cover the full 5- and 6-bit code space, so out-of-range values appear often. Strobe rates are chosen so that TICs, writes and code periods collide in the same cycle many times.

// File: rtl/epoch_pkg.sv
package epoch_pkg;
  localparam int DEF_MS_MOD  = 20;
  localparam int DEF_BIT_MOD = 50;

  typedef enum logic {
    LOAD_NOW    = 1'b0,
    LOAD_AT_TIC = 1'b1
  } load_mode_e;
endpackage

// File: rtl/epoch_digit.sv
module epoch_digit #(
  parameter int MOD = 20,
  localparam int W = $clog2(MOD)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         inc_i,
  output logic [W-1:0] value_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] TOP = W'(MOD - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load_i)      cnt_q <= load_val_i;
    else if (inc_i)       cnt_q <= (cnt_q == TOP) ? '0 : cnt_q + 1'b1;
  end

  assign value_o = cnt_q;
  assign wrap_o  = inc_i && (cnt_q == TOP);

  // R2
  digit_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= TOP);

  // R2
  digit_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (inc_i && !load_i && cnt_q == TOP) |=> (cnt_q == '0));

  // R2
  digit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!inc_i && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/epoch_preload.sv
module epoch_preload
  import epoch_pkg::*;
#(
  parameter int MS_MOD  = DEF_MS_MOD,
  parameter int BIT_MOD = DEF_BIT_MOD,
  localparam int MS_W  = $clog2(MS_MOD),
  localparam int BIT_W = $clog2(BIT_MOD)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  logic             defer_i,
  input  logic [MS_W-1:0]  ms_i,
  input  logic [BIT_W-1:0] bit_i,
  input  logic             tic_i,
  output logic             load_o,
  output logic [MS_W-1:0]  ms_o,
  output logic [BIT_W-1:0] bit_o
);
  logic             pend_q;
  logic [MS_W-1:0]  pms_q;
  logic [BIT_W-1:0] pbit_q;
  logic [MS_W-1:0]  ms_fix;
  logic [BIT_W-1:0] bit_fix;
  logic             wr_now, wr_tic;

  // R9: out-of-range fields become 0
  assign ms_fix  = (ms_i  < MS_W'(MS_MOD))   ? ms_i  : '0;
  assign bit_fix = (bit_i < BIT_W'(BIT_MOD)) ? bit_i : '0;

  assign wr_now = wr_i && (load_mode_e'(defer_i) == LOAD_NOW);
  assign wr_tic = wr_i && (load_mode_e'(defer_i) == LOAD_AT_TIC);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      pms_q  <= '0;
      pbit_q <= '0;
    end else if (wr_now) begin
      pend_q <= 1'b0;
    end else if (wr_tic) begin
      pend_q <= 1'b1;
      pms_q  <= ms_fix;
      pbit_q <= bit_fix;
    end else if (tic_i) begin
      pend_q <= 1'b0;
    end
  end

  assign load_o = wr_now || (tic_i && pend_q);
  assign ms_o   = wr_now ? ms_fix  : pms_q;
  assign bit_o  = wr_now ? bit_fix : pbit_q;

  // R6
  pend_once_chk: assert property (@(posedge clk) disable iff (rst)
    (tic_i && pend_q && !wr_tic) |=> !pend_q);

  // R5
  pend_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !tic_i && !wr_i) |=> (pend_q && $stable(pms_q) && $stable(pbit_q)));

  // R10
  pend_arm_chk: assert property (@(posedge clk) disable iff (rst)
    wr_tic |=> pend_q);
endmodule

// File: rtl/code_epoch_tracker.sv
module code_epoch_tracker
  import epoch_pkg::*;
#(
  parameter int MS_MOD  = DEF_MS_MOD,
  parameter int BIT_MOD = DEF_BIT_MOD,
  localparam int MS_W  = $clog2(MS_MOD),
  localparam int BIT_W = $clog2(BIT_MOD)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             period_stb,
  input  logic             tic_stb,
  input  logic             ld_wr,
  input  logic             ld_deferred,
  input  logic [MS_W-1:0]  ld_ms,
  input  logic [BIT_W-1:0] ld_bit,
  output logic [MS_W-1:0]  live_ms,
  output logic [BIT_W-1:0] live_bit,
  output logic [MS_W-1:0]  snap_ms,
  output logic [BIT_W-1:0] snap_bit
);
  logic             load;
  logic [MS_W-1:0]  load_ms;
  logic [BIT_W-1:0] load_bit;
  logic             ms_wrap, bit_wrap;
  logic [MS_W-1:0]  ms_q;
  logic [BIT_W-1:0] bit_q;

  epoch_preload #(.MS_MOD(MS_MOD), .BIT_MOD(BIT_MOD)) u_pre (
    .clk(clk), .rst(rst), .wr_i(ld_wr), .defer_i(ld_deferred),
    .ms_i(ld_ms), .bit_i(ld_bit), .tic_i(tic_stb),
    .load_o(load), .ms_o(load_ms), .bit_o(load_bit)
  );

  epoch_digit #(.MOD(MS_MOD)) u_ms (
    .clk(clk), .rst(rst), .load_i(load), .load_val_i(load_ms),
    .inc_i(period_stb), .value_o(ms_q), .wrap_o(ms_wrap)
  );

  epoch_digit #(.MOD(BIT_MOD)) u_bit (
    .clk(clk), .rst(rst), .load_i(load), .load_val_i(load_bit),
    .inc_i(ms_wrap), .value_o(bit_q), .wrap_o(bit_wrap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_ms  <= '0;
      snap_bit <= '0;
    end else if (tic_stb) begin
      snap_ms  <= ms_q;
      snap_bit <= bit_q;
    end
  end

  assign live_ms  = ms_q;
  assign live_bit = bit_q;

  // R7
  snap_capture_chk: assert property (@(posedge clk) disable iff (rst)
    tic_stb |=> (snap_ms == $past(live_ms) && snap_bit == $past(live_bit)));

  // R7
  snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tic_stb |=> ($stable(snap_ms) && $stable(snap_bit)));

  // R3
  frame_roll_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_wrap && !load) |=> (live_ms == '0 && live_bit == '0));

  // R3
  carry_chk: assert property (@(posedge clk) disable iff (rst)
    (period_stb && !load && live_ms == MS_W'(MS_MOD - 1) && live_bit != BIT_W'(BIT_MOD - 1))
      |=> (live_bit == $past(live_bit) + 1'b1));

  // R4
  now_load_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_wr && !ld_deferred && ld_ms < MS_W'(MS_MOD) && ld_bit < BIT_W'(BIT_MOD))
      |=> (live_ms == $past(ld_ms) && live_bit == $past(ld_bit)));
endmodule

// File: tb/code_epoch_tracker_tb_top.sv
`timescale 1ns/1ps
module code_epoch_tracker_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic period_stb = 0, tic_stb = 0, ld_wr = 0, ld_deferred = 0;
  logic [4:0] ld_ms = '0;
  logic [5:0] ld_bit = '0;
  logic [4:0] live_ms, snap_ms;
  logic [5:0] live_bit, snap_bit;

  int checks = 0;
  int errors = 0;

  int m_ms, m_bit, s_ms, s_bit, p_ms, p_bit;
  bit p_v;

  always #2 clk = ~clk;

  code_epoch_tracker dut_i (
    .clk(clk), .rst(rst), .period_stb(period_stb), .tic_stb(tic_stb),
    .ld_wr(ld_wr), .ld_deferred(ld_deferred), .ld_ms(ld_ms), .ld_bit(ld_bit),
    .live_ms(live_ms), .live_bit(live_bit), .snap_ms(snap_ms), .snap_bit(snap_bit)
  );

  function automatic int fix(int v, int m);
    return (v < m) ? v : 0;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare(string req);
    chk(req, "live_ms", live_ms, m_ms);
    chk(req, "live_bit", live_bit, m_bit);
    chk(req, "snap_ms", snap_ms, s_ms);
    chk(req, "snap_bit", snap_bit, s_bit);
  endtask

  // one clock: apply inputs, update reference, compare after the edge
  task automatic step(string req, bit p, bit t, bit w, bit d, int vm, int vb);
    period_stb = p; tic_stb = t; ld_wr = w; ld_deferred = d;
    ld_ms = 5'(vm); ld_bit = 6'(vb);
    @(posedge clk);
    if (t) begin s_ms = m_ms; s_bit = m_bit; end
    if (w && !d) begin
      m_ms = fix(vm, 20); m_bit = fix(vb, 50);
    end else if (t && p_v) begin
      m_ms = p_ms; m_bit = p_bit;
    end else if (p) begin
      if (m_ms == 19) begin m_ms = 0; m_bit = (m_bit == 49) ? 0 : m_bit + 1; end
      else m_ms = m_ms + 1;
    end
    if (w && !d) p_v = 0;
    else if (w && d) begin p_v = 1; p_ms = fix(vm, 20); p_bit = fix(vb, 50); end
    else if (t) p_v = 0;
    #1;
    compare(req);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    period_stb = 1; tic_stb = 1; ld_wr = 0;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    m_ms = 0; m_bit = 0; s_ms = 0; s_bit = 0; p_v = 0; p_ms = 0; p_bit = 0;
    period_stb = 0; tic_stb = 0;
    compare("R1");
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    // R2: inner counts to 19, R3: carry into outer
    for (int i = 0; i < 19; i++) step("R2", 1, 0, 0, 0, 0, 0);
    chk("R2", "inner at 19", live_ms, 19);
    step("R3", 1, 0, 0, 0, 0, 0);
    chk("R3", "carry outer", live_bit, 1);
    // R3: full-frame rollover
    step("R4", 0, 0, 1, 0, 19, 49);
    step("R3", 1, 0, 0, 0, 0, 0);
    chk("R3", "frame wrap ms", live_ms, 0);
    chk("R3", "frame wrap bit", live_bit, 0);
    // R4: immediate load beats a same-cycle strobe
    step("R4", 1, 0, 1, 0, 7, 33);
    chk("R4", "immediate ms", live_ms, 7);
    // R5: deferred hold, replaced by a later write, applied at TIC
    step("R5", 1, 0, 1, 1, 5, 7);
    step("R5", 1, 0, 1, 1, 9, 11);
    step("R5", 1, 0, 0, 0, 0, 0);
    step("R5", 1, 1, 0, 0, 0, 0);
    chk("R5", "deferred ms", live_ms, 9);
    chk("R5", "deferred bit", live_bit, 11);
    // R6: second TIC does not reload
    step("R6", 1, 0, 0, 0, 0, 0);
    step("R6", 1, 1, 0, 0, 0, 0);
    chk("R6", "no reload", live_ms, 11);
    // R7: TIC with strobe snapshots pre-increment value
    step("R7", 1, 1, 0, 0, 0, 0);
    chk("R7", "snap pre-increment", snap_ms, 11);
    // R9: out-of-range fields load as zero
    step("R9", 0, 0, 1, 0, 25, 60);
    chk("R9", "range ms", live_ms, 0);
    chk("R9", "range bit", live_bit, 0);
    step("R9", 0, 0, 1, 0, 3, 55);
    chk("R9", "mixed ms kept", live_ms, 3);
    // R10: deferred write at a TIC waits for the next TIC
    step("R10", 0, 1, 1, 1, 12, 20);
    chk("R10", "not yet", live_ms, 3);
    step("R10", 0, 1, 0, 0, 0, 0);
    chk("R10", "next tic ms", live_ms, 12);
    // R4: immediate write cancels pending
    step("R4", 0, 0, 1, 1, 17, 40);
    step("R4", 0, 0, 1, 0, 2, 2);
    step("R4", 0, 1, 0, 0, 0, 0);
    chk("R4", "cancel ms", live_ms, 2);
    // R8: random traffic
    for (int i = 0; i < 4000; i++) begin
      bit p, t, w, d;
      p = ($urandom % 2) == 0;
      t = ($urandom % 37) == 0;
      w = ($urandom % 53) == 0;
      d = ($urandom % 2) == 0;
      step("R8", p, t, w, d, int'($urandom % 32), int'($urandom % 64));
    end
    // R1: reset mid-run clears pending too
    step("R1", 0, 0, 1, 1, 6, 6);
    do_reset();
    step("R1", 0, 1, 0, 0, 0, 0);
    chk("R1", "pending dropped", live_ms, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule